// File: doc/BRIEF.md
# Digital Audio Routing Crossbar

This block is a switch matrix that sits between a chip's external serial audio ports and its internal audio controllers. Each side carries the same bundle of four signals: a bit clock, a frame sync and two serial data lines. A small 32-bit register interface sets up the routing. For every external port, software names its source. The source is either an internal controller or another external port. For every controller, software names the port that supplies its clock and frame sync, and the port that feeds each of its two data inputs.

Two external ports can be linked so that audio passes straight between two outside devices. In a link, each side carries its own master bit. A master port drives bit clock and frame sync toward its device, using the clocks it receives from the peer port. A slave port leaves its clock pins undriven. Several ports may name the same controller, which lets one stream go out on many ports at once. All routing is combinational logic fed from the registers, so a register write changes the signal paths in the very next cycle.

Top module: `audio_route_xbar`

## Requirements
- R1: Reset clears every register to zero. As a result, every port is sourced from controller 0 with its clock output enable high and both data output enables low, and every controller takes all of its signals from port 0.
- R2: The port registers sit at byte offset 4*p (p = 0..4). The controller registers sit at 0x40 + 4*c (c = 0..2). A read returns the register on bus_rdata in the cycle after the access strobe. Undefined bits read as 0.
- R3: Layout of a port register: bit 31 is master, bit 30 enables transmit on data line 1, bit 29 enables transmit on data line 2, and bits 4:0 hold the source code. Source codes 0..2 select controllers 0..2. Codes 16..20 select ports 0..4.
- R4: Layout of a controller register: bits 3:0 select the port for clock and frame sync, bits 27:24 the port for data line 1, and bits 31:28 the port for data line 2. Values 0..4 select ports 0..4.
- R5: A port sourced from a controller outputs that controller's bit clock, frame sync and both data lines, with the clock output enable high.
- R6: A port linked to another port outputs the peer's pad data inputs. If the master bit is set, it also outputs the peer's bit clock and frame sync with the clock enable high. If the master bit is clear, its clock outputs and clock enable are 0.
- R7: For a port with a defined source, each data output enable equals that line's transmit bit.
- R8: A port source code outside the defined sets drives 0 on all four outputs and on all three enables. A controller select value of 5 or more feeds 0 to the controller.
- R9: Several ports may select the same controller at once. Each of them then carries that controller's signals.
- R10: An access to any other offset, misaligned ones included, returns bus_rdata = 0, raises bus_err for exactly the cycle after the strobe, and leaves every register unchanged.
- R11: A register write changes the routing outputs in the first cycle after the write's clock edge.
- R12: A controller's bit clock and frame sync come from the port chosen by its clock field. Its data 1 and data 2 come independently from the ports chosen by their own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| ctl_bclk_i | input | NUM_CTRL (3) | Bit clock driven by each controller |
| ctl_fs_i | input | NUM_CTRL (3) | Frame sync driven by each controller |
| ctl_d1_i | input | NUM_CTRL (3) | Data line 1 driven by each controller |
| ctl_d2_i | input | NUM_CTRL (3) | Data line 2 driven by each controller |
| ctl_bclk_o | output | NUM_CTRL (3) | Bit clock delivered to each controller |
| ctl_fs_o | output | NUM_CTRL (3) | Frame sync delivered to each controller |
| ctl_d1_o | output | NUM_CTRL (3) | Data line 1 delivered to each controller |
| ctl_d2_o | output | NUM_CTRL (3) | Data line 2 delivered to each controller |
| pad_bclk_i | input | NUM_PORTS (5) | Bit clock received at each port pad |
| pad_fs_i | input | NUM_PORTS (5) | Frame sync received at each port pad |
| pad_d1_i | input | NUM_PORTS (5) | Data line 1 received at each port pad |
| pad_d2_i | input | NUM_PORTS (5) | Data line 2 received at each port pad |
| pad_bclk_o | output | NUM_PORTS (5) | Bit clock driven to each port pad |
| pad_fs_o | output | NUM_PORTS (5) | Frame sync driven to each port pad |
| pad_d1_o | output | NUM_PORTS (5) | Data line 1 driven to each port pad |
| pad_d2_o | output | NUM_PORTS (5) | Data line 2 driven to each port pad |
| pad_clk_oe | output | NUM_PORTS (5) | Output enable for each port's bit clock and frame sync |
| pad_d1_oe | output | NUM_PORTS (5) | Output enable for each port's data line 1 |
| pad_d2_oe | output | NUM_PORTS (5) | Output enable for each port's data line 2 |

## Verification
A bad stored configuration shows up at once on the routing outputs, because nothing sits between the registers and the pads. A wrong source code puts the wrong controller's or peer's level on a pad, or raises an enable on an undefined or slave link, in the very cycle after the write. The reference model compares every pad and controller output on every clock while the inputs toggle at random. A wrong value is therefore caught within one cycle of the edge at which it appears. Decode faults show up one cycle after the strobe, as a wrong read word, a missing or stretched bus_err pulse, or a register changed by a rejected access.

// File: rtl/audio_xbar_pkg.sv
package audio_xbar_pkg;

   localparam int SRC_W         = 5;
   localparam int SEL_W         = 4;
   localparam int LINK_BASE     = 16;
   localparam int REG_STRIDE    = 4;
   localparam int WORD_W        = 32;
   localparam logic [WORD_W-1:0] PORT_WORD_MASK = 32'hE000_001F;
   localparam logic [WORD_W-1:0] CTL_WORD_MASK  = 32'hFF00_000F;

   typedef struct packed {
      logic             master;
      logic             d1_tx;
      logic             d2_tx;
      logic [SRC_W-1:0] src;
   } port_cfg_t;

   typedef struct packed {
      logic [SEL_W-1:0] d2_sel;
      logic [SEL_W-1:0] d1_sel;
      logic [SEL_W-1:0] clk_sel;
   } ctl_cfg_t;

   function automatic logic [WORD_W-1:0] port_to_word(port_cfg_t c);
      logic [WORD_W-1:0] w;
      w        = '0;
      w[31]    = c.master;
      w[30]    = c.d1_tx;
      w[29]    = c.d2_tx;
      w[4:0]   = c.src;
      return w;
   endfunction

   function automatic port_cfg_t word_to_port(logic [WORD_W-1:0] w);
      port_cfg_t c;
      c.master = w[31];
      c.d1_tx  = w[30];
      c.d2_tx  = w[29];
      c.src    = w[4:0];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] ctl_to_word(ctl_cfg_t c);
      logic [WORD_W-1:0] w;
      w        = '0;
      w[31:28] = c.d2_sel;
      w[27:24] = c.d1_sel;
      w[3:0]   = c.clk_sel;
      return w;
   endfunction

   function automatic ctl_cfg_t word_to_ctl(logic [WORD_W-1:0] w);
      ctl_cfg_t c;
      c.d2_sel  = w[31:28];
      c.d1_sel  = w[27:24];
      c.clk_sel = w[3:0];
      return c;
   endfunction

endpackage

// File: rtl/xbar_pick.sv
module xbar_pick #(
   parameter int N       = 3,
   parameter int SEL_W   = 5,
   parameter bit ONEHOT  = 1'b0
) (
   input  logic [N-1:0]     vec,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_o
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2)      $error("xbar_pick: N must be at least 2");
   if (SEL_W < IW) $error("xbar_pick: select too narrow for N");

   if (ONEHOT) begin : g_onehot
      logic [N-1:0] hit;
      always_comb begin
         for (int i = 0; i < N; i++) begin
            hit[i] = (sel == SEL_W'(i));
         end
         bit_o = |(vec & hit);
      end
   end else begin : g_index
      always_comb begin
         bit_o = 1'b0;
         if (int'(sel) < N) begin
            bit_o = vec[sel[IW-1:0]];
         end
      end
   end

endmodule

// File: rtl/xbar_regfile.sv
module xbar_regfile
   import audio_xbar_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int NUM_CTRL  = 3,
   parameter int ADDR_W    = 8,
   parameter int PORT_BASE = 'h00,
   parameter int CTRL_BASE = 'h40
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_en,
   input  logic                              bus_we,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [WORD_W-1:0]                 bus_wdata,
   output logic [WORD_W-1:0]                 bus_rdata,
   output logic                              bus_err,
   output port_cfg_t [NUM_PORTS-1:0]         port_cfg,
   output ctl_cfg_t  [NUM_CTRL-1:0]          ctl_cfg
);

   localparam int PORT_END = PORT_BASE + REG_STRIDE * NUM_PORTS;
   localparam int CTRL_END = CTRL_BASE + REG_STRIDE * NUM_CTRL;

   if (PORT_END > CTRL_BASE)   $error("xbar_regfile: port and controller windows overlap");
   if (CTRL_END > (1 << ADDR_W)) $error("xbar_regfile: controller window exceeds address space");

   logic [NUM_PORTS-1:0] hit_p;
   logic [NUM_CTRL-1:0]  hit_c;
   logic                 any_hit;
   logic [WORD_W-1:0]    rd_word;

   always_comb begin
      for (int i = 0; i < NUM_PORTS; i++) begin
         hit_p[i] = bus_en && (bus_addr == ADDR_W'(PORT_BASE + REG_STRIDE * i));
      end
      for (int j = 0; j < NUM_CTRL; j++) begin
         hit_c[j] = bus_en && (bus_addr == ADDR_W'(CTRL_BASE + REG_STRIDE * j));
      end
      any_hit = (|hit_p) || (|hit_c);
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (hit_p[i]) rd_word = port_to_word(port_cfg[i]);
      end
      for (int j = 0; j < NUM_CTRL; j++) begin
         if (hit_c[j]) rd_word = ctl_to_word(ctl_cfg[j]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_cfg <= '0;
         ctl_cfg  <= '0;
      end else if (bus_we) begin
         for (int i = 0; i < NUM_PORTS; i++) begin
            if (hit_p[i]) port_cfg[i] <= word_to_port(bus_wdata);
         end
         for (int j = 0; j < NUM_CTRL; j++) begin
            if (hit_c[j]) ctl_cfg[j] <= word_to_ctl(bus_wdata);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= (bus_en && !bus_we) ? rd_word : '0;
         bus_err   <= bus_en && !any_hit;
      end
   end

   // R10: a rejected access leaves all registers untouched
   a_r10_bad_access_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !any_hit) |=> (port_cfg == $past(port_cfg) && ctl_cfg == $past(ctl_cfg)));

   // R10: error pulse only follows a strobe, and carries zero data
   a_r10_err_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($past(bus_en) && bus_rdata == '0));

   // R10: error lasts one cycle unless a second bad strobe came
   a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !bus_en) |=> !bus_err);

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_wchk_p
      // R11: a write lands in the addressed port register next cycle
      a_r11_port_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_p[i] && bus_we) |=> port_to_word(port_cfg[i]) == ($past(bus_wdata) & PORT_WORD_MASK));
   end

   for (genvar j = 0; j < NUM_CTRL; j++) begin : g_wchk_c
      // R11: a write lands in the addressed controller register next cycle
      a_r11_ctl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_c[j] && bus_we) |=> ctl_to_word(ctl_cfg[j]) == ($past(bus_wdata) & CTL_WORD_MASK));
   end

endmodule

// File: rtl/xbar_port_route.sv
module xbar_port_route
   import audio_xbar_pkg::*;
#(
   parameter int NUM_PORTS  = 5,
   parameter int NUM_CTRL   = 3,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  port_cfg_t            cfg,
   input  logic [NUM_CTRL-1:0]  ctl_bclk,
   input  logic [NUM_CTRL-1:0]  ctl_fs,
   input  logic [NUM_CTRL-1:0]  ctl_d1,
   input  logic [NUM_CTRL-1:0]  ctl_d2,
   input  logic [NUM_PORTS-1:0] pad_bclk,
   input  logic [NUM_PORTS-1:0] pad_fs,
   input  logic [NUM_PORTS-1:0] pad_d1,
   input  logic [NUM_PORTS-1:0] pad_d2,
   output logic                 bclk_o,
   output logic                 fs_o,
   output logic                 d1_o,
   output logic                 d2_o,
   output logic                 clk_oe,
   output logic                 d1_oe,
   output logic                 d2_oe
);

   localparam int NSIG = 4;

   logic [NSIG-1:0][NUM_CTRL-1:0]  ctl_vec;
   logic [NSIG-1:0][NUM_PORTS-1:0] pad_vec;
   logic [NSIG-1:0]                from_ctl_bits;
   logic [NSIG-1:0]                from_pad_bits;
   logic [SRC_W-1:0]               pad_idx;
   logic                           is_ctl;
   logic                           is_link;

   assign ctl_vec = {ctl_bclk, ctl_fs, ctl_d1, ctl_d2};
   assign pad_vec = {pad_bclk, pad_fs, pad_d1, pad_d2};
   assign pad_idx = cfg.src - SRC_W'(LINK_BASE);

   always_comb begin
      is_ctl  = int'(cfg.src) < NUM_CTRL;
      is_link = (int'(cfg.src) >= LINK_BASE) && (int'(cfg.src) < LINK_BASE + NUM_PORTS);
   end

   for (genvar k = 0; k < NSIG; k++) begin : g_sig
      xbar_pick #(.N(NUM_CTRL), .SEL_W(SRC_W), .ONEHOT(ONEHOT_MUX)) u_ctl_pick (
         .vec   (ctl_vec[k]),
         .sel   (cfg.src),
         .bit_o (from_ctl_bits[k])
      );
      xbar_pick #(.N(NUM_PORTS), .SEL_W(SRC_W), .ONEHOT(ONEHOT_MUX)) u_pad_pick (
         .vec   (pad_vec[k]),
         .sel   (pad_idx),
         .bit_o (from_pad_bits[k])
      );
   end

   always_comb begin
      bclk_o = 1'b0;
      fs_o   = 1'b0;
      d1_o   = 1'b0;
      d2_o   = 1'b0;
      clk_oe = 1'b0;
      if (is_ctl) begin
         {bclk_o, fs_o, d1_o, d2_o} = from_ctl_bits;
         clk_oe = 1'b1;
      end else if (is_link) begin
         d1_o = from_pad_bits[1];
         d2_o = from_pad_bits[0];
         if (cfg.master) begin
            bclk_o = from_pad_bits[3];
            fs_o   = from_pad_bits[2];
            clk_oe = 1'b1;
         end
      end
      d1_oe = (is_ctl || is_link) && cfg.d1_tx;
      d2_oe = (is_ctl || is_link) && cfg.d2_tx;
   end

endmodule

// File: rtl/xbar_ctl_route.sv
module xbar_ctl_route
   import audio_xbar_pkg::*;
#(
   parameter int NUM_PORTS  = 5,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  ctl_cfg_t             cfg,
   input  logic [NUM_PORTS-1:0] pad_bclk,
   input  logic [NUM_PORTS-1:0] pad_fs,
   input  logic [NUM_PORTS-1:0] pad_d1,
   input  logic [NUM_PORTS-1:0] pad_d2,
   output logic                 bclk_o,
   output logic                 fs_o,
   output logic                 d1_o,
   output logic                 d2_o
);

   localparam int NSIG = 4;

   logic [NSIG-1:0][NUM_PORTS-1:0] pad_vec;
   logic [NSIG-1:0][SEL_W-1:0]     sel_vec;
   logic [NSIG-1:0]                picked;

   assign pad_vec = {pad_bclk, pad_fs, pad_d1, pad_d2};
   assign sel_vec = {cfg.clk_sel, cfg.clk_sel, cfg.d1_sel, cfg.d2_sel};

   for (genvar k = 0; k < NSIG; k++) begin : g_sig
      xbar_pick #(.N(NUM_PORTS), .SEL_W(SEL_W), .ONEHOT(ONEHOT_MUX)) u_pick (
         .vec   (pad_vec[k]),
         .sel   (sel_vec[k]),
         .bit_o (picked[k])
      );
   end

   assign {bclk_o, fs_o, d1_o, d2_o} = picked;

endmodule

// File: rtl/audio_route_xbar.sv
module audio_route_xbar
   import audio_xbar_pkg::*;
#(
   parameter int NUM_PORTS  = 5,
   parameter int NUM_CTRL   = 3,
   parameter int ADDR_W     = 8,
   parameter int PORT_BASE  = 'h00,
   parameter int CTRL_BASE  = 'h40,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 bus_err,
   input  logic [NUM_CTRL-1:0]  ctl_bclk_i,
   input  logic [NUM_CTRL-1:0]  ctl_fs_i,
   input  logic [NUM_CTRL-1:0]  ctl_d1_i,
   input  logic [NUM_CTRL-1:0]  ctl_d2_i,
   output logic [NUM_CTRL-1:0]  ctl_bclk_o,
   output logic [NUM_CTRL-1:0]  ctl_fs_o,
   output logic [NUM_CTRL-1:0]  ctl_d1_o,
   output logic [NUM_CTRL-1:0]  ctl_d2_o,
   input  logic [NUM_PORTS-1:0] pad_bclk_i,
   input  logic [NUM_PORTS-1:0] pad_fs_i,
   input  logic [NUM_PORTS-1:0] pad_d1_i,
   input  logic [NUM_PORTS-1:0] pad_d2_i,
   output logic [NUM_PORTS-1:0] pad_bclk_o,
   output logic [NUM_PORTS-1:0] pad_fs_o,
   output logic [NUM_PORTS-1:0] pad_d1_o,
   output logic [NUM_PORTS-1:0] pad_d2_o,
   output logic [NUM_PORTS-1:0] pad_clk_oe,
   output logic [NUM_PORTS-1:0] pad_d1_oe,
   output logic [NUM_PORTS-1:0] pad_d2_oe
);

   if (NUM_PORTS < 2 || NUM_PORTS > (1 << SEL_W))
      $error("audio_route_xbar: NUM_PORTS out of range");
   if (NUM_CTRL < 2 || NUM_CTRL > LINK_BASE)
      $error("audio_route_xbar: NUM_CTRL out of range");
   if (LINK_BASE + NUM_PORTS > (1 << SRC_W))
      $error("audio_route_xbar: link codes exceed source field");

   port_cfg_t [NUM_PORTS-1:0] port_cfg;
   ctl_cfg_t  [NUM_CTRL-1:0]  ctl_cfg;

   xbar_regfile #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_CTRL  (NUM_CTRL),
      .ADDR_W    (ADDR_W),
      .PORT_BASE (PORT_BASE),
      .CTRL_BASE (CTRL_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .port_cfg  (port_cfg),
      .ctl_cfg   (ctl_cfg)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      xbar_port_route #(
         .NUM_PORTS  (NUM_PORTS),
         .NUM_CTRL   (NUM_CTRL),
         .ONEHOT_MUX (ONEHOT_MUX)
      ) u_route (
         .cfg      (port_cfg[p]),
         .ctl_bclk (ctl_bclk_i),
         .ctl_fs   (ctl_fs_i),
         .ctl_d1   (ctl_d1_i),
         .ctl_d2   (ctl_d2_i),
         .pad_bclk (pad_bclk_i),
         .pad_fs   (pad_fs_i),
         .pad_d1   (pad_d1_i),
         .pad_d2   (pad_d2_i),
         .bclk_o   (pad_bclk_o[p]),
         .fs_o     (pad_fs_o[p]),
         .d1_o     (pad_d1_o[p]),
         .d2_o     (pad_d2_o[p]),
         .clk_oe   (pad_clk_oe[p]),
         .d1_oe    (pad_d1_oe[p]),
         .d2_oe    (pad_d2_oe[p])
      );

      logic src_ctl;
      logic src_link;
      assign src_ctl  = int'(port_cfg[p].src) < NUM_CTRL;
      assign src_link = (int'(port_cfg[p].src) >= LINK_BASE) &&
                        (int'(port_cfg[p].src) < LINK_BASE + NUM_PORTS);

      // R5: a controller-sourced port always drives its clocks
      a_r5_ctl_clk_oe: assert property (@(posedge clk) disable iff (!rst_n)
         src_ctl |-> pad_clk_oe[p]);

      // R6: a slave in a link never drives clock or frame sync
      a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (src_link && !port_cfg[p].master) |-> (!pad_clk_oe[p] && !pad_bclk_o[p] && !pad_fs_o[p]));

      // R7: data enables follow the transmit bits on a defined source
      a_r7_dir_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (src_ctl || src_link) |-> (pad_d1_oe[p] == port_cfg[p].d1_tx && pad_d2_oe[p] == port_cfg[p].d2_tx));

      // R8: an undefined source code drives nothing
      a_r8_undefined_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_ctl && !src_link) |-> (!pad_clk_oe[p] && !pad_d1_oe[p] && !pad_d2_oe[p] &&
                                      !pad_bclk_o[p] && !pad_fs_o[p] && !pad_d1_o[p] && !pad_d2_o[p]));
   end

   for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctl
      xbar_ctl_route #(
         .NUM_PORTS  (NUM_PORTS),
         .ONEHOT_MUX (ONEHOT_MUX)
      ) u_route (
         .cfg      (ctl_cfg[c]),
         .pad_bclk (pad_bclk_i),
         .pad_fs   (pad_fs_i),
         .pad_d1   (pad_d1_i),
         .pad_d2   (pad_d2_i),
         .bclk_o   (ctl_bclk_o[c]),
         .fs_o     (ctl_fs_o[c]),
         .d1_o     (ctl_d1_o[c]),
         .d2_o     (ctl_d2_o[c])
      );

      // R8: an out-of-range clock select feeds zero to the controller
      a_r8_ctl_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(ctl_cfg[c].clk_sel) >= NUM_PORTS) |-> (!ctl_bclk_o[c] && !ctl_fs_o[c]));
   end

endmodule

// File: tb/sim_audio_route_xbar.sv
`timescale 1ns/1ps
module sim_audio_route_xbar;

   localparam int NP = 5;
   localparam int NC = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err;
   logic [NC-1:0] ctl_bclk_i = '0, ctl_fs_i = '0, ctl_d1_i = '0, ctl_d2_i = '0;
   logic [NC-1:0] ctl_bclk_o, ctl_fs_o, ctl_d1_o, ctl_d2_o;
   logic [NP-1:0] pad_bclk_i = '0, pad_fs_i = '0, pad_d1_i = '0, pad_d2_i = '0;
   logic [NP-1:0] pad_bclk_o, pad_fs_o, pad_d1_o, pad_d2_o;
   logic [NP-1:0] pad_clk_oe, pad_d1_oe, pad_d2_oe;

   audio_route_xbar u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .ctl_bclk_i(ctl_bclk_i), .ctl_fs_i(ctl_fs_i), .ctl_d1_i(ctl_d1_i), .ctl_d2_i(ctl_d2_i),
      .ctl_bclk_o(ctl_bclk_o), .ctl_fs_o(ctl_fs_o), .ctl_d1_o(ctl_d1_o), .ctl_d2_o(ctl_d2_o),
      .pad_bclk_i(pad_bclk_i), .pad_fs_i(pad_fs_i), .pad_d1_i(pad_d1_i), .pad_d2_i(pad_d2_i),
      .pad_bclk_o(pad_bclk_o), .pad_fs_o(pad_fs_o), .pad_d1_o(pad_d1_o), .pad_d2_o(pad_d2_o),
      .pad_clk_oe(pad_clk_oe), .pad_d1_oe(pad_d1_oe), .pad_d2_oe(pad_d2_oe)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit audio_run = 1'b1;

   // reference model state
   logic [31:0] m_port [NP];
   logic [31:0] m_ctl  [NC];
   logic [31:0] exp_rdata = '0;
   logic        exp_err = 1'b0;

   initial begin
      for (int i = 0; i < NP; i++) m_port[i] = '0;
      for (int j = 0; j < NC; j++) m_ctl[j] = '0;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural register model, updated at each rising edge
   always @(posedge clk) begin
      int a, kind, idx;
      if (!rst_n) begin
         for (int i = 0; i < NP; i++) m_port[i] = '0;
         for (int j = 0; j < NC; j++) m_ctl[j] = '0;
         exp_rdata = '0;
         exp_err   = 1'b0;
      end else begin
         a = int'(bus_addr);
         kind = 0;
         idx = 0;
         if (a % 4 == 0 && a / 4 < NP) begin
            kind = 1; idx = a / 4;
         end else if (a >= 64 && (a - 64) % 4 == 0 && (a - 64) / 4 < NC) begin
            kind = 2; idx = (a - 64) / 4;
         end
         exp_rdata = '0;
         exp_err   = 1'b0;
         if (bus_en) begin
            exp_err = (kind == 0);
            if (bus_we) begin
               if (kind == 1) m_port[idx] = bus_wdata & 32'hE000_001F;
               if (kind == 2) m_ctl[idx]  = bus_wdata & 32'hFF00_000F;
            end else begin
               if (kind == 1) exp_rdata = m_port[idx];
               if (kind == 2) exp_rdata = m_ctl[idx];
            end
         end
      end
   end

   function automatic logic [6:0] exp_port(int p);
      logic [31:0] w;
      int src, q;
      w   = m_port[p];
      src = int'(w[4:0]);
      if (src < NC)
         return {ctl_bclk_i[src], ctl_fs_i[src], ctl_d1_i[src], ctl_d2_i[src], 1'b1, w[30], w[29]};
      if (src >= 16 && src < 16 + NP) begin
         q = src - 16;
         return {w[31] & pad_bclk_i[q], w[31] & pad_fs_i[q], pad_d1_i[q], pad_d2_i[q],
                 w[31], w[30], w[29]};
      end
      return 7'b0;
   endfunction

   function automatic logic [3:0] exp_ctl(int c);
      int cs, s1, s2;
      logic [3:0] r;
      cs = int'(m_ctl[c][3:0]);
      s1 = int'(m_ctl[c][27:24]);
      s2 = int'(m_ctl[c][31:28]);
      r  = '0;
      if (cs < NP) begin r[3] = pad_bclk_i[cs]; r[2] = pad_fs_i[cs]; end
      if (s1 < NP) r[1] = pad_d1_i[s1];
      if (s2 < NP) r[0] = pad_d2_i[s2];
      return r;
   endfunction

   // per-cycle comparison against the model (R5 R6 R8 R12 R2 R10)
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         for (int p = 0; p < NP; p++) begin
            int src;
            string tag;
            src = int'(m_port[p][4:0]);
            tag = (src < NC) ? "R5 port from controller" :
                  (src >= 16 && src < 16 + NP) ? "R6 port link" : "R8 undefined source";
            chk(tag, 32'({pad_bclk_o[p], pad_fs_o[p], pad_d1_o[p], pad_d2_o[p],
                          pad_clk_oe[p], pad_d1_oe[p], pad_d2_oe[p]}), 32'(exp_port(p)));
         end
         for (int c = 0; c < NC; c++) begin
            chk("R12 controller inputs", 32'({ctl_bclk_o[c], ctl_fs_o[c], ctl_d1_o[c], ctl_d2_o[c]}),
                32'(exp_ctl(c)));
         end
         chk(exp_err ? "R10 read data on bad offset" : "R2 read data", bus_rdata, exp_rdata);
         chk("R10 error pulse", 32'(bus_err), 32'(exp_err));
      end
   end

   // audio inputs toggle away from both edges the checks use
   always @(posedge clk) begin
      if (audio_run) begin
         #1;
         ctl_bclk_i = NC'($urandom); ctl_fs_i = NC'($urandom);
         ctl_d1_i   = NC'($urandom); ctl_d2_i = NC'($urandom);
         pad_bclk_i = NP'($urandom); pad_fs_i = NP'($urandom);
         pad_d1_i   = NP'($urandom); pad_d2_i = NP'($urandom);
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
      @(negedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk); #1;
      bus_en = 1'b0;
      d = bus_rdata;
      e = bus_err;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic        er;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk); #1;

      // R1: reset state of the routing and of every register
      chk("R1 clock enables after reset", 32'(pad_clk_oe), 32'h1F);
      chk("R1 data enables after reset", 32'({pad_d1_oe, pad_d2_oe}), 32'h0);
      for (int i = 0; i < NP; i++) begin
         bus_read(8'(4 * i), rd, er);
         chk("R1 port register reset", rd, 32'h0);
      end
      for (int j = 0; j < NC; j++) begin
         bus_read(8'(64 + 4 * j), rd, er);
         chk("R1 controller register reset", rd, 32'h0);
      end

      // R2 R3: port field layout and masking of undefined bits
      bus_write(8'h08, 32'hFFFF_FFF1);
      bus_read(8'h08, rd, er);
      chk("R3 port field readback", rd, 32'hE000_0011);
      chk("R2 no error on valid read", 32'(er), 32'h0);

      // R4 R12: controller field layout and independent selects
      bus_write(8'h44, 32'h3412_3452);
      bus_read(8'h44, rd, er);
      chk("R4 controller field readback", rd, 32'h3400_0002);
      chk("R12 data1 from port 4", 32'(ctl_d1_o[1]), 32'(pad_d1_i[4]));
      chk("R12 clock from port 2", 32'(ctl_bclk_o[1]), 32'(pad_bclk_i[2]));

      // R10: bad offsets, including misaligned and out of window
      bus_read(8'h14, rd, er);
      chk("R10 gap offset data", rd, 32'h0);
      chk("R10 gap offset error", 32'(er), 32'h1);
      @(negedge clk); #1;
      chk("R10 error lasts one cycle", 32'(bus_err), 32'h0);
      bus_write(8'h4C, 32'hFFFF_FFFF);
      bus_write(8'h03, 32'h0000_001F);
      bus_read(8'h00, rd, er);
      chk("R10 misaligned write ignored", rd, 32'h0);
      bus_read(8'h02, rd, er);
      chk("R10 misaligned read error", 32'(er), 32'h1);

      // R11: the new route is live in the first cycle after the write
      bus_write(8'h10, 32'h2000_0000);
      chk("R11 data2 enable right after write", 32'(pad_d2_oe[4]), 32'h1);
      chk("R11 data2 follows controller 0", 32'(pad_d2_o[4]), 32'(ctl_d2_i[0]));

      // R7: each data enable follows its own transmit bit
      bus_write(8'h00, 32'h2000_0001);
      chk("R7 data1 enable off", 32'(pad_d1_oe[0]), 32'h0);
      chk("R7 data2 enable on", 32'(pad_d2_oe[0]), 32'h1);

      // R8: undefined source codes and controller selects
      bus_write(8'h04, 32'hE000_0005);
      chk("R8 code 5 silent", 32'({pad_clk_oe[1], pad_d1_oe[1], pad_d2_oe[1]}), 32'h0);
      bus_write(8'h04, 32'hE000_0015);
      chk("R8 code 21 silent", 32'({pad_clk_oe[1], pad_d1_oe[1], pad_d2_oe[1]}), 32'h0);
      bus_write(8'h48, 32'h7700_0009);
      chk("R8 controller select 9 gives zero", 32'({ctl_bclk_o[2], ctl_fs_o[2], ctl_d1_o[2], ctl_d2_o[2]}), 32'h0);

      // R6: slave link leaves clocks undriven, master link drives them
      bus_write(8'h0C, 32'h4000_0014);
      chk("R6 slave clock enable off", 32'(pad_clk_oe[3]), 32'h0);
      chk("R6 slave data1 from peer", 32'(pad_d1_o[3]), 32'(pad_d1_i[4]));
      bus_write(8'h0C, 32'h8000_0014);
      chk("R6 master clock enable on", 32'(pad_clk_oe[3]), 32'h1);
      chk("R6 master bit clock from peer", 32'(pad_bclk_o[3]), 32'(pad_bclk_i[4]));

      // R9: three ports broadcasting controller 2
      bus_write(8'h00, 32'h0000_0002);
      bus_write(8'h04, 32'h0000_0002);
      bus_write(8'h08, 32'h0000_0002);
      for (int r = 0; r < 4; r++) begin
         @(negedge clk); #1;
         chk("R9 broadcast clock", 32'(pad_bclk_o[2:0]), 32'({3{ctl_bclk_i[2]}}));
         chk("R9 broadcast data1", 32'(pad_d1_o[2:0]), 32'({3{ctl_d1_i[2]}}));
      end

      // random traffic over valid and invalid offsets, model-checked each cycle
      for (int n = 0; n < 400; n++) begin
         logic [7:0] a;
         a = 8'($urandom_range(0, 79));
         if ($urandom_range(0, 3) != 0) a = a & 8'hFC;
         if ($urandom_range(0, 1) == 0) bus_write(a, $urandom);
         else bus_read(a, rd, er);
      end

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule